// File: doc/BRIEF.md
# Alias-aware complex inner-product engine

This block computes, for each row of a pair of complex matrices, the sum of A elements times the complex conjugate of the matching B elements. Commands wait in a small internal queue. Each command names where A and B start in memory, where the per-row results go, and the row and column counts. The engine runs one command at a time. For every row it reads the A row as a burst into a row buffer, then reads the B row and accumulates as the beats arrive. It then writes one complex result word for that row.

The engine compares the A and B addresses once, when it takes a command from the queue. If they are equal, it issues no B burst. The B lanes are taken from the row buffer that already holds A, and that slot keeps its place in the schedule, so the schedule stays the same. In that case the read traffic is half, while the command takes the same number of cycles. Beat counters and a cycle counter, cleared when each command is taken, let a user observe both effects.

Top module: `cip_engine`

## Requirements
- R1: For row i, the result word holds, in bits [79:40], the real part of the sum over j of A[i][j]·conj(B[i][j]), which is sum(ar·br + ai·bi). Bits [39:0] hold the imaginary part, sum(ai·br − ar·bi). Both are 40-bit two's complement. A read beat carries the real part in bits [31:16] and the imaginary part in bits [15:0], both 16-bit signed.
- R2: When the A and B addresses of a command are equal, no B read request is issued and `rd_beats` ends at rows·cols. Otherwise it ends at 2·rows·cols (a 4×4 command gives 16 and 32). The equality flag does not change while the command runs.
- R3: When the memory accepts requests at once and returns one beat per cycle starting the cycle after the request, `cmd_cycles` ends at rows·(2·cols+4). This count is the same whether or not the addresses are equal.
- R4: For row i the A burst has address a+i·cols and length cols. When a B burst is issued for row i, it has address b+i·cols and length cols. A request holds its address and length until it is accepted.
- R5: Each row produces one write request of length 1 at address y+i, issued in row order. `wr_beats` ends at rows. Write data holds steady until accepted.
- R6: Commands complete in the order they were queued. A command's first read request comes only after the previous command's last write beat. `done` pulses for one cycle with `busy` low.
- R7: The queue holds up to 4 pending commands. `cmd_ready` is low exactly when all 4 are taken.
- R8: After reset, `busy`, `done` and all request, valid and ready outputs are low, `cmd_ready` is high, and the counters read 0.
- R9: Stall cycles on any request or data handshake do not change the results, the beat counts or the request addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Queue has room |
| cmd_a_addr | input | 16 | A start word address |
| cmd_b_addr | input | 16 | B start word address |
| cmd_y_addr | input | 16 | Result start word address |
| cmd_rows | input | 5 | Row count, 1..16 |
| cmd_cols | input | 5 | Column count, 1..16 |
| rd_req_valid | output | 1 | Read burst request |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 16 | Read burst start address |
| rd_req_len | output | 5 | Read burst length in beats |
| rd_valid | input | 1 | Read beat present |
| rd_ready | output | 1 | Engine takes read beat |
| rd_data | input | 32 | Complex operand element |
| wr_req_valid | output | 1 | Write burst request |
| wr_req_ready | input | 1 | Write request accepted |
| wr_req_addr | output | 16 | Write start address |
| wr_req_len | output | 5 | Write burst length (always 1) |
| wr_valid | output | 1 | Write beat present |
| wr_ready | input | 1 | Memory takes write beat |
| wr_data | output | 80 | Complex result word |
| busy | output | 1 | A command is running |
| done | output | 1 | One-cycle completion pulse |
| rd_beats | output | 16 | Read beats of current/last command |
| wr_beats | output | 16 | Write beats of current/last command |
| cmd_cycles | output | 16 | Busy cycles of current/last command |

## Verification
The assertions assume that row and column counts lie in 1..16 and that the memory does not present a read beat when no burst is outstanding. The bench only queues commands with legal dimensions. Its memory model gives beats only for an accepted burst and stops after the requested length. The cycle-count check is made only in passes where the memory never stalls. Separate passes stall every handshake at random and check only data, counts and addresses.

// File: rtl/cip_engine.sv
module cip_engine #(
  parameter int AW       = 16,
  parameter int DW       = 5,
  parameter int EW       = 16,
  parameter int ACC_W    = 40,
  parameter int MAX_DIM  = 16,
  parameter int CQ_DEPTH = 4,
  parameter int CNT_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [AW-1:0]        cmd_a_addr,
  input  logic [AW-1:0]        cmd_b_addr,
  input  logic [AW-1:0]        cmd_y_addr,
  input  logic [DW-1:0]        cmd_rows,
  input  logic [DW-1:0]        cmd_cols,
  output logic                 rd_req_valid,
  input  logic                 rd_req_ready,
  output logic [AW-1:0]        rd_req_addr,
  output logic [DW-1:0]        rd_req_len,
  input  logic                 rd_valid,
  output logic                 rd_ready,
  input  logic [2*EW-1:0]      rd_data,
  output logic                 wr_req_valid,
  input  logic                 wr_req_ready,
  output logic [AW-1:0]        wr_req_addr,
  output logic [DW-1:0]        wr_req_len,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic [2*ACC_W-1:0]   wr_data,
  output logic                 busy,
  output logic                 done,
  output logic [CNT_W-1:0]     rd_beats,
  output logic [CNT_W-1:0]     wr_beats,
  output logic [CNT_W-1:0]     cmd_cycles
);
  localparam int CMD_W = 3*AW + 2*DW;
  localparam int QP_W  = (CQ_DEPTH > 1) ? $clog2(CQ_DEPTH) : 1;
  localparam int IDX_W = (MAX_DIM > 1) ? $clog2(MAX_DIM) : 1;
  localparam int PW    = 2*EW + 1;
  localparam logic [QP_W:0] Q_FULL = (QP_W+1)'(CQ_DEPTH);

  typedef enum logic [2:0] {
    S_IDLE, S_RA_REQ, S_RA_DAT, S_RB_REQ, S_RB_DAT, S_WR_REQ, S_WR_DAT
  } st_t;

  st_t st;

  logic [CMD_W-1:0] q_mem [CQ_DEPTH];
  logic [QP_W-1:0]  q_wp, q_rp;
  logic [QP_W:0]    q_cnt;
  logic             push, pop;

  assign cmd_ready = (q_cnt != Q_FULL);
  assign push      = cmd_valid && cmd_ready;
  assign pop       = (st == S_IDLE) && (q_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_wp  <= '0;
      q_rp  <= '0;
      q_cnt <= '0;
    end else begin
      if (push) q_wp <= q_wp + 1'b1;
      if (pop)  q_rp <= q_rp + 1'b1;
      case ({push, pop})
        2'b10:   q_cnt <= q_cnt + 1'b1;
        2'b01:   q_cnt <= q_cnt - 1'b1;
        default: q_cnt <= q_cnt;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (push) q_mem[q_wp] <= {cmd_a_addr, cmd_b_addr, cmd_y_addr, cmd_rows, cmd_cols};

  logic [AW-1:0] h_a, h_b, h_y;
  logic [DW-1:0] h_r, h_c;
  assign {h_a, h_b, h_y, h_r, h_c} = q_mem[q_rp];

  logic [AW-1:0]   a_ptr, b_ptr, y_ptr;
  logic [DW-1:0]   nrows, ncols, row, col;
  logic            ab_eq;
  logic signed [ACC_W-1:0] acc_re, acc_im;
  logic [2*EW-1:0] abuf [MAX_DIM];

  logic [IDX_W-1:0] cidx;
  logic [2*EW-1:0]  a_word, b_word;
  logic signed [PW-1:0] ar, ai, br, bi, p_re, p_im;
  logic beat_b, last_col, last_row;

  assign cidx     = col[IDX_W-1:0];
  assign a_word   = abuf[cidx];
  assign b_word   = ab_eq ? a_word : rd_data;
  assign ar       = PW'($signed(a_word[2*EW-1:EW]));
  assign ai       = PW'($signed(a_word[EW-1:0]));
  assign br       = PW'($signed(b_word[2*EW-1:EW]));
  assign bi       = PW'($signed(b_word[EW-1:0]));
  assign p_re     = ar*br + ai*bi;
  assign p_im     = ai*br - ar*bi;
  assign beat_b   = (st == S_RB_DAT) && (ab_eq || rd_valid);
  assign last_col = (col + 1'b1 == ncols);
  assign last_row = (row + 1'b1 == nrows);

  assign rd_req_valid = (st == S_RA_REQ) || (st == S_RB_REQ && !ab_eq);
  assign rd_req_addr  = (st == S_RA_REQ) ? a_ptr : b_ptr;
  assign rd_req_len   = ncols;
  assign rd_ready     = (st == S_RA_DAT) || (st == S_RB_DAT && !ab_eq);
  assign wr_req_valid = (st == S_WR_REQ);
  assign wr_req_addr  = y_ptr;
  assign wr_req_len   = DW'(1);
  assign wr_valid     = (st == S_WR_DAT);
  assign wr_data      = {acc_re, acc_im};
  assign busy         = (st != S_IDLE);

  always_ff @(posedge clk)
    if (st == S_RA_DAT && rd_valid) abuf[cidx] <= rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      a_ptr      <= '0;
      b_ptr      <= '0;
      y_ptr      <= '0;
      nrows      <= '0;
      ncols      <= '0;
      row        <= '0;
      col        <= '0;
      ab_eq      <= 1'b0;
      acc_re     <= '0;
      acc_im     <= '0;
      done       <= 1'b0;
      rd_beats   <= '0;
      wr_beats   <= '0;
      cmd_cycles <= '0;
    end else begin
      done <= 1'b0;
      if (busy) cmd_cycles <= cmd_cycles + 1'b1;
      if (rd_valid && rd_ready) rd_beats <= rd_beats + 1'b1;
      if (wr_valid && wr_ready) wr_beats <= wr_beats + 1'b1;
      case (st)
        S_IDLE: if (pop) begin
          a_ptr      <= h_a;
          b_ptr      <= h_b;
          y_ptr      <= h_y;
          nrows      <= h_r;
          ncols      <= h_c;
          ab_eq      <= (h_a == h_b);
          row        <= '0;
          rd_beats   <= '0;
          wr_beats   <= '0;
          cmd_cycles <= '0;
          st         <= S_RA_REQ;
        end
        S_RA_REQ: if (rd_req_ready) begin
          col <= '0;
          st  <= S_RA_DAT;
        end
        S_RA_DAT: if (rd_valid) begin
          col <= col + 1'b1;
          if (last_col) st <= S_RB_REQ;
        end
        S_RB_REQ: if (ab_eq || rd_req_ready) begin
          col    <= '0;
          acc_re <= '0;
          acc_im <= '0;
          st     <= S_RB_DAT;
        end
        S_RB_DAT: if (beat_b) begin
          acc_re <= acc_re + ACC_W'(p_re);
          acc_im <= acc_im + ACC_W'(p_im);
          col    <= col + 1'b1;
          if (last_col) st <= S_WR_REQ;
        end
        S_WR_REQ: if (wr_req_ready) st <= S_WR_DAT;
        S_WR_DAT: if (wr_ready) begin
          if (last_row) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            row   <= row + 1'b1;
            a_ptr <= a_ptr + AW'(ncols);
            b_ptr <= b_ptr + AW'(ncols);
            y_ptr <= y_ptr + 1'b1;
            st    <= S_RA_REQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cip_engine_chk.sv
module cip_engine_chk #(
  parameter int AW    = 16,
  parameter int DW    = 5,
  parameter int ACC_W = 40,
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic               rd_req_valid,
  input logic               rd_req_ready,
  input logic [AW-1:0]      rd_req_addr,
  input logic [DW-1:0]      rd_req_len,
  input logic               rd_ready,
  input logic               wr_req_valid,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic [2*ACC_W-1:0] wr_data,
  input logic               ab_eq,
  input logic [DW-1:0]      nrows,
  input logic [DW-1:0]      ncols,
  input logic [CNT_W-1:0]   rd_beats
);
  int rd_limit;
  assign rd_limit = int'(nrows) * int'(ncols) * (ab_eq ? 1 : 2);

  AST_RDREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_len)); // R4
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data)); // R5
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req_valid, rd_ready, wr_req_valid, wr_valid})); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(ab_eq)); // R2
  AST_RD_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> int'(rd_beats) <= rd_limit); // R2
endmodule

bind cip_engine cip_engine_chk #(.AW(AW), .DW(DW), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
  .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len), .rd_ready(rd_ready),
  .wr_req_valid(wr_req_valid), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_data(wr_data), .ab_eq(ab_eq), .nrows(nrows), .ncols(ncols),
  .rd_beats(rd_beats)
);

// File: tb/test_cip_engine.sv
`timescale 1ns/1ps
module test_cip_engine;
  localparam int AW = 16, DW = 5, EW = 16, ACC_W = 40, MAX_DIM = 16, CQ_DEPTH = 4, CNT_W = 16;
  localparam int MEM_N = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic cmd_valid = 1'b0, cmd_ready;
  logic [AW-1:0] cmd_a_addr = '0, cmd_b_addr = '0, cmd_y_addr = '0;
  logic [DW-1:0] cmd_rows = '0, cmd_cols = '0;
  logic rd_req_valid, rd_req_ready, rd_valid, rd_ready;
  logic [AW-1:0] rd_req_addr, wr_req_addr;
  logic [DW-1:0] rd_req_len, wr_req_len;
  logic [2*EW-1:0] rd_data;
  logic wr_req_valid, wr_req_ready, wr_valid, wr_ready;
  logic [2*ACC_W-1:0] wr_data;
  logic busy, done;
  logic [CNT_W-1:0] rd_beats, wr_beats, cmd_cycles;

  cip_engine #(.AW(AW), .DW(DW), .EW(EW), .ACC_W(ACC_W), .MAX_DIM(MAX_DIM),
               .CQ_DEPTH(CQ_DEPTH), .CNT_W(CNT_W)) i_cip_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_a_addr(cmd_a_addr), .cmd_b_addr(cmd_b_addr), .cmd_y_addr(cmd_y_addr),
    .cmd_rows(cmd_rows), .cmd_cols(cmd_cols),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready),
    .wr_req_addr(wr_req_addr), .wr_req_len(wr_req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .busy(busy), .done(done), .rd_beats(rd_beats), .wr_beats(wr_beats),
    .cmd_cycles(cmd_cycles)
  );

  logic [31:0] mem [MEM_N];
  logic [79:0] ymem [MEM_N];
  logic [AW-1:0] rq_addr [64];
  int rq_len [64];
  logic [AW-1:0] wq_addr [64];
  int wq_len [64];
  int rq_n = 0, wq_n = 0, rbeat_n = 0, wbeat_n = 0;
  bit stall_mode = 1'b0;
  int n_chk = 0, n_err = 0;

  function automatic logic [31:0] lfsr(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  // behavioural memory: samples at posedge, drives at negedge
  initial begin
    int r_addr, r_left, w_addr;
    logic [31:0] rng;
    rng = 32'h1234_5678; r_addr = 0; r_left = 0; w_addr = 0;
    rd_valid = 1'b0; rd_data = '0; rd_req_ready = 1'b1; wr_req_ready = 1'b1; wr_ready = 1'b1;
    forever begin
      @(posedge clk);
      if (rd_req_valid && rd_req_ready) begin
        r_addr = int'(rd_req_addr); r_left = int'(rd_req_len);
        if (rq_n < 64) begin rq_addr[rq_n] = rd_req_addr; rq_len[rq_n] = int'(rd_req_len); end
        rq_n++;
      end
      if (rd_valid && rd_ready) begin r_addr++; r_left--; rbeat_n++; end
      if (wr_req_valid && wr_req_ready) begin
        w_addr = int'(wr_req_addr);
        if (wq_n < 64) begin wq_addr[wq_n] = wr_req_addr; wq_len[wq_n] = int'(wr_req_len); end
        wq_n++;
      end
      if (wr_valid && wr_ready) begin ymem[w_addr % MEM_N] = wr_data; wbeat_n++; end
      @(negedge clk);
      rng = lfsr(rng); rng = lfsr(rng);
      rd_valid     = (r_left > 0) && (!stall_mode || rng[0]);
      rd_data      = mem[r_addr % MEM_N];
      rd_req_ready = !stall_mode || rng[3];
      wr_req_ready = !stall_mode || rng[5];
      wr_ready     = !stall_mode || rng[7];
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ev(input int w, input bit hi);
    return hi ? longint'($signed(mem[w % MEM_N][31:16])) : longint'($signed(mem[w % MEM_N][15:0]));
  endfunction

  task automatic check_rows(input int a, input int b, input int y, input int r, input int c, input string tag);
    for (int i = 0; i < r; i++) begin
      longint er, ei, ar, ai, br, bi;
      er = 0; ei = 0;
      for (int j = 0; j < c; j++) begin
        ar = ev(a + i*c + j, 1); ai = ev(a + i*c + j, 0);
        br = ev(b + i*c + j, 1); bi = ev(b + i*c + j, 0);
        er += ar*br + ai*bi;
        ei += ai*br - ar*bi;
      end
      check(longint'($signed(ymem[(y+i) % MEM_N][79:40])) == er, {tag, " real"},
            longint'($signed(ymem[(y+i) % MEM_N][79:40])), er);
      check(longint'($signed(ymem[(y+i) % MEM_N][39:0])) == ei, {tag, " imag"},
            longint'($signed(ymem[(y+i) % MEM_N][39:0])), ei);
    end
  endtask

  task automatic push_cmd(input int a, input int b, input int y, input int r, input int c);
    @(negedge clk);
    cmd_a_addr = AW'(a); cmd_b_addr = AW'(b); cmd_y_addr = AW'(y);
    cmd_rows = DW'(r); cmd_cols = DW'(c); cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 20000 && !ok; k++) begin
      @(negedge clk);
      if (done) ok = 1'b1;
    end
  endtask

  task automatic run_one(input int a, input int b, input int y, input int r, input int c, output int cyc);
    bit ok;
    int exp_rd, nreq;
    string t;
    t = stall_mode ? "R9" : "R1";
    @(negedge clk);
    rq_n = 0; wq_n = 0; rbeat_n = 0; wbeat_n = 0;
    for (int i = 0; i < r; i++) ymem[(y+i) % MEM_N] = '0;
    push_cmd(a, b, y, r, c);
    wait_done(ok);
    check(ok, "R6 done seen", longint'(ok), 1);
    check(!busy, "R6 busy low at done", longint'(busy), 0);
    cyc = int'(cmd_cycles);
    check_rows(a, b, y, r, c, t);
    exp_rd = (a == b) ? r*c : 2*r*c;
    check(int'(rd_beats) == exp_rd, stall_mode ? "R9 rd_beats" : "R2 rd_beats", rd_beats, exp_rd);
    check(rbeat_n == exp_rd, stall_mode ? "R9 bus read beats" : "R2 bus read beats", rbeat_n, exp_rd);
    nreq = (a == b) ? r : 2*r;
    check(rq_n == nreq, "R2 read request count", rq_n, nreq);
    for (int k = 0; k < nreq && k < rq_n && k < 64; k++) begin
      int row, ea;
      row = (a == b) ? k : k/2;
      ea = ((a == b) || (k % 2 == 0)) ? a + row*c : b + row*c;
      check(int'(rq_addr[k]) == ea && rq_len[k] == c, stall_mode ? "R9 read address" : "R4 read address",
            int'(rq_addr[k]), ea);
    end
    check(int'(wr_beats) == r && wbeat_n == r, "R5 write beats", wr_beats, r);
    for (int k = 0; k < r && k < wq_n; k++)
      check(int'(wq_addr[k]) == y + k && wq_len[k] == 1, "R5 write address", int'(wq_addr[k]), y + k);
    if (!stall_mode)
      check(cyc == r*(2*c+4), "R3 cycle count", cyc, r*(2*c+4));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] s;
    int ca, cn, ndone;
    s = 32'hACE1_0001;
    for (int k = 0; k < MEM_N; k++) begin
      s = lfsr(s); s = lfsr(s); s = lfsr(s);
      mem[k] = s;
      ymem[k] = '0;
    end
    mem[0] = {16'h8000, 16'h8000};
    mem[1] = {16'h7FFF, 16'h8000};
    mem[2] = {16'h8000, 16'h7FFF};

    repeat (5) @(negedge clk);
    check(!busy && !done, "R8 busy/done reset", {busy, done}, 0);
    check(!rd_req_valid && !rd_ready && !wr_req_valid && !wr_valid, "R8 handshakes reset",
          {rd_req_valid, rd_ready, wr_req_valid, wr_valid}, 0);
    check(cmd_ready, "R8 cmd_ready reset", cmd_ready, 1);
    check(rd_beats == 0 && wr_beats == 0 && cmd_cycles == 0, "R8 counters reset", cmd_cycles, 0);
    rst_n = 1'b1;

    for (int r = 1; r <= 4; r++)
      for (int c = 1; c <= 4; c++) begin
        run_one(0, 0, 600, r, c, ca);
        run_one(0, 300, 620, r, c, cn);
        check(ca == cn, "R3 equal latency alias vs distinct", ca, cn);
      end
    run_one(0, 0, 900, 16, 16, ca);
    run_one(0, 512, 920, 16, 16, cn);
    check(ca == cn, "R3 equal latency 16x16", ca, cn);
    run_one(7, 7, 940, 3, 16, ca);
    run_one(7, 400, 950, 3, 16, cn);
    check(ca == cn, "R3 equal latency 3x16", ca, cn);

    stall_mode = 1'b1;
    for (int r = 1; r <= 4; r += 3)
      for (int c = 2; c <= 16; c += 7) begin
        run_one(40, 40, 700, r, c, ca);
        run_one(40, 200, 720, r, c, cn);
      end
    stall_mode = 1'b0;

    @(negedge clk);
    wq_n = 0;
    for (int k = 0; k < 5; k++) push_cmd(10*k, (k % 2 == 0) ? 10*k : 500 + 10*k, 800 + 4*k, 2, 3);
    check(!cmd_ready, "R7 queue full after five pushes", cmd_ready, 0);
    ndone = 0;
    for (int t = 0; t < 2000 && ndone < 5; t++) begin
      @(negedge clk);
      if (done) ndone++;
    end
    check(ndone == 5, "R6 five completions", ndone, 5);
    check(cmd_ready, "R7 queue drained", cmd_ready, 1);
    for (int k = 0; k < 10 && k < wq_n; k++)
      check(int'(wq_addr[k]) == 800 + 4*(k/2) + (k%2), "R6 completion order",
            int'(wq_addr[k]), 800 + 4*(k/2) + (k%2));
    for (int k = 0; k < 5; k++)
      check_rows(10*k, (k % 2 == 0) ? 10*k : 500 + 10*k, 800 + 4*k, 2, 3, "R6 queued result");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule